// File: doc/BRIEF.md
# ADC Conversion Control Register Block

This block is the register front end of one multiplexed analog-to-digital converter. Software reaches it through a plain register read/write port. It holds configuration for power, trigger source, interrupt enable and the conversion sequence. It keeps two status flags and the last conversion result. When software asks for a conversion, the block hands a start pulse and a channel number to a converter model. It waits for that model's done strobe, latches the 12-bit result and raises an end-of-conversion flag. It also drives an interrupt line when that flag's interrupt is enabled.

Conversions are gated three ways. The converter must be powered. A fixed stabilization window must have passed since power-on. The external trigger selection must be zero, so that a software start is meaningful. Only a single conversion on the first sequence channel is performed. The scan, per-conversion flagging and sequence length fields are held for software but do not change the conversion flow. The sequence length uses a minus-one encoding, so 0 means one conversion.

Top module: `adcctl_top`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `convStart` is 0.
- R2: Writable fields read back at their offsets and all other bits read 0. At 0x04, bit 8 is scan enable and bit 5 is the end-of-conversion interrupt enable. At 0x08, bit 0 is power, bit 10 is per-conversion flagging and bits 29:28 are the trigger selection. At 0x2C, bits 23:20 hold the sequence length minus one. At 0x34, bits 4:0 hold the first channel.
- R3: A write to 0x08 that sets bit 30 (software start) with a nonzero value in bits 29:28 starts nothing: `convStart` stays 0 and status bit 4 stays 0.
- R4: A start request is ignored while power (0x08 bit 0) is off. It is also ignored until STAB_CYCLES clock edges have passed with power on. A start at the STAB_CYCLES-th edge after the power-on write is ignored, and one at the next edge is honoured. Turning power off restarts the window.
- R5: An honoured start gives a one-cycle `convStart` pulse in the cycle after the write. During that pulse `convChan` equals 0x34 bits 4:0. Status bit 4 (started) is set at the same edge, and 0x08 bit 30 reads back 0.
- R6: A `convDone` during a conversion latches `convResult` into 0x4C bits 11:0, with bits 31:12 reading 0. It sets status bit 1 (end of conversion) in the following cycle.
- R7: `irq` is 1 exactly when status bit 1 and 0x04 bit 5 are both 1.
- R8: A read of 0x4C clears status bit 1. Writing 0 to status bit 1 or bit 4 clears that flag, and writing 1 leaves it unchanged.
- R9: A start request made while a conversion is in progress produces no further `convStart`.
- R10: A `convDone` while no conversion is in progress changes neither the result register nor the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convChan | output | 5 | Channel to convert |
| convDone | input | 1 | Converter result valid strobe |
| convResult | input | 12 | Converter result |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
Read data is combinational, so the bench samples it in the same cycle that the address is driven. A register write is visible from the first cycle after its edge. `convStart` is due exactly one edge after the accepted write and is gone one edge later. The bench checks it directly after the write returns, and again one cycle on. The result, the end-of-conversion flag and `irq` are due one edge after `convDone`. A read of 0x4C clears the flag at the edge that ends the read, so the flag is checked with a separate status read afterwards. The stabilization boundary is hit exactly: the bench counts idle cycles after the power-on write so that two start attempts land on the last ignored edge and the first honoured edge.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_CFG_IRQ  = 8'h04;
  localparam logic [7:0] OFS_CFG_PWR  = 8'h08;
  localparam logic [7:0] OFS_SEQ_LEN  = 8'h2C;
  localparam logic [7:0] OFS_SEQ_CHAN = 8'h34;
  localparam logic [7:0] OFS_RESULT   = 8'h4C;

  localparam int BIT_DONE_FLAG = 1;
  localparam int BIT_STARTED   = 4;
  localparam int BIT_SCAN      = 8;
  localparam int BIT_DONE_IE   = 5;
  localparam int BIT_POWER     = 0;
  localparam int BIT_PER_CONV  = 10;
  localparam int BIT_TRIG_LO   = 28;
  localparam int BIT_SW_GO     = 30;
  localparam int BIT_LEN_LO    = 20;
  localparam int LEN_W         = 4;

  typedef struct packed {
    logic launch;   // conversion accepted this cycle
    logic capture;  // result valid this cycle
  } ctrlStrobe_t;

  typedef enum logic {ST_IDLE, ST_BUSY} convState_t;

endpackage

// File: rtl/adcctl_ctrl.sv
module adcctl_ctrl
  import adcctl_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerOn,
  input  logic        startReq,
  input  logic        convDone,
  output ctrlStrobe_t strobe,
  output logic        convStart
);

  localparam int CNT_W = $clog2(STAB_CYCLES + 2);
  localparam logic [CNT_W-1:0] STAB_LIMIT = CNT_W'(STAB_CYCLES);

  logic [CNT_W-1:0] stabCnt;
  logic             ready;
  convState_t       state;

  assign ready = (stabCnt == STAB_LIMIT);

  always_comb begin
    strobe.launch  = startReq & powerOn & ready & (state == ST_IDLE);
    strobe.capture = convDone & powerOn & (state == ST_BUSY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt   <= '0;
      state     <= ST_IDLE;
      convStart <= 1'b0;
    end else if (!powerOn) begin
      stabCnt   <= '0;
      state     <= ST_IDLE;
      convStart <= 1'b0;
    end else begin
      if (!ready) stabCnt <= stabCnt + 1'b1;
      convStart <= strobe.launch;
      if (strobe.launch)       state <= ST_BUSY;
      else if (strobe.capture) state <= ST_IDLE;
    end
  end

  // R5: start is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R9: no new start while a conversion has been running for a cycle
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && $past(state == ST_BUSY)) |-> !convStart);

  // R4: a start pulse follows only a fully stabilized, powered cycle
  a_r4_start_after_stab: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> ($past(ready) && $past(powerOn)));

endmodule

// File: rtl/adcctl_regs.sv
module adcctl_regs
  import adcctl_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  ctrlStrobe_t       strobe,
  input  logic [RES_W-1:0]  convResult,
  output logic              powerOn,
  output logic              startReq,
  output logic [CHAN_W-1:0] convChan,
  output logic              irq
);

  localparam int PAD_W = 32 - RES_W;

  logic             scanEn, doneIrqEn, perConvFlag;
  logic [1:0]       trigSel;
  logic [LEN_W-1:0] seqLenM1;
  logic [RES_W-1:0] resultReg;
  logic             doneFlag, startedFlag;
  logic             wrStatus, wrCfgIrq, wrCfgPwr, wrSeqLen, wrSeqChan, rdResult;
  logic             unusedWdata;

  assign unusedWdata = ^busWdata;

  assign wrStatus  = busSel & busWrite & (busAddr == OFS_STATUS);
  assign wrCfgIrq  = busSel & busWrite & (busAddr == OFS_CFG_IRQ);
  assign wrCfgPwr  = busSel & busWrite & (busAddr == OFS_CFG_PWR);
  assign wrSeqLen  = busSel & busWrite & (busAddr == OFS_SEQ_LEN);
  assign wrSeqChan = busSel & busWrite & (busAddr == OFS_SEQ_CHAN);
  assign rdResult  = busSel & ~busWrite & (busAddr == OFS_RESULT);

  assign startReq = wrCfgPwr & busWdata[BIT_SW_GO] & busWdata[BIT_POWER]
                  & (busWdata[BIT_TRIG_LO+1:BIT_TRIG_LO] == 2'b00);

  assign irq = doneFlag & doneIrqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanEn      <= 1'b0;
      doneIrqEn   <= 1'b0;
      powerOn     <= 1'b0;
      perConvFlag <= 1'b0;
      trigSel     <= 2'b00;
      seqLenM1    <= '0;
      convChan    <= '0;
    end else begin
      if (wrCfgIrq) begin
        scanEn    <= busWdata[BIT_SCAN];
        doneIrqEn <= busWdata[BIT_DONE_IE];
      end
      if (wrCfgPwr) begin
        powerOn     <= busWdata[BIT_POWER];
        perConvFlag <= busWdata[BIT_PER_CONV];
        trigSel     <= busWdata[BIT_TRIG_LO+1:BIT_TRIG_LO];
      end
      if (wrSeqLen)  seqLenM1 <= busWdata[BIT_LEN_LO+LEN_W-1:BIT_LEN_LO];
      if (wrSeqChan) convChan <= busWdata[CHAN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg   <= '0;
      doneFlag    <= 1'b0;
      startedFlag <= 1'b0;
    end else begin
      if (strobe.capture) resultReg <= convResult;

      if (strobe.capture)                             doneFlag <= 1'b1;
      else if (rdResult)                              doneFlag <= 1'b0;
      else if (wrStatus && !busWdata[BIT_DONE_FLAG])  doneFlag <= 1'b0;

      if (strobe.launch)                              startedFlag <= 1'b1;
      else if (wrStatus && !busWdata[BIT_STARTED])    startedFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_STATUS: begin
        busRdata[BIT_DONE_FLAG] = doneFlag;
        busRdata[BIT_STARTED]   = startedFlag;
      end
      OFS_CFG_IRQ: begin
        busRdata[BIT_SCAN]    = scanEn;
        busRdata[BIT_DONE_IE] = doneIrqEn;
      end
      OFS_CFG_PWR: begin
        busRdata[BIT_POWER]                   = powerOn;
        busRdata[BIT_PER_CONV]                = perConvFlag;
        busRdata[BIT_TRIG_LO+1:BIT_TRIG_LO]   = trigSel;
      end
      OFS_SEQ_LEN:  busRdata[BIT_LEN_LO+LEN_W-1:BIT_LEN_LO] = seqLenM1;
      OFS_SEQ_CHAN: busRdata[CHAN_W-1:0] = convChan;
      OFS_RESULT:   busRdata = {{PAD_W{1'b0}}, resultReg};
      default:      busRdata = '0;
    endcase
  end

  // R3: the started flag only rises from an accepted start
  a_r3_started_from_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startedFlag) |-> $past(strobe.launch));

  // R6: the done flag only rises from a capture strobe
  a_r6_done_from_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(strobe.capture));

  // R8: a result read without a simultaneous capture leaves the flag clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdResult) && !$past(strobe.capture)) |-> !doneFlag);

  // R10: the result register holds unless a capture occurred
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(resultReg));

endmodule

// File: rtl/adcctl_top.sv
module adcctl_top
  import adcctl_pkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int RES_W       = 12,
  parameter int CHAN_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq
);

  ctrlStrobe_t strobe;
  logic        powerOn;
  logic        startReq;

  adcctl_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerOn  (powerOn),
    .startReq (startReq),
    .convDone (convDone),
    .strobe   (strobe),
    .convStart(convStart)
  );

  adcctl_regs #(.RES_W(RES_W), .CHAN_W(CHAN_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .strobe    (strobe),
    .convResult(convResult),
    .powerOn   (powerOn),
    .startReq  (startReq),
    .convChan  (convChan),
    .irq       (irq)
  );

  // R7: interrupt line follows flag and enable one cycle after a capture
  a_r7_irq_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) |-> (irq == busRdataIrqEn));

  logic busRdataIrqEn;
  assign busRdataIrqEn = u_regs.doneIrqEn;

endmodule

// File: tb/sim_adcctl_top.sv
`timescale 1ns/1ps
module sim_adcctl_top;

  localparam int STAB = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        convStart;
  logic [4:0]  convChan;
  logic        convDone = 1'b0;
  logic [11:0] convResult = 12'h0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adcctl_top #(.STAB_CYCLES(STAB)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convResult(convResult), .irq(irq)
  );

  // addr(8) | write data(32) | expected readback(32)
  localparam int NVEC = 7;
  localparam logic [71:0] REG_VEC [NVEC] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0120},
    {8'h04, 32'h0000_0020, 32'h0000_0020},
    {8'h08, 32'h1000_0400, 32'h1000_0400},
    {8'h2C, 32'hFFFF_FFFF, 32'h00F0_0000},
    {8'h34, 32'hFFFF_FFEA, 32'h0000_000A},
    {8'h08, 32'h0000_0000, 32'h0000_0000},
    {8'h2C, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; the write happens at the next posedge
  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic convRespond(input logic [11:0] v);
    convDone = 1'b1; convResult = v;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(8'h00, rd); check("R1 status", rd, 32'h0);
    busRd(8'h04, rd); check("R1 cfg irq", rd, 32'h0);
    busRd(8'h08, rd); check("R1 cfg pwr", rd, 32'h0);
    busRd(8'h2C, rd); check("R1 seq len", rd, 32'h0);
    busRd(8'h34, rd); check("R1 seq chan", rd, 32'h0);
    busRd(8'h4C, rd); check("R1 result", rd, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 convStart", {31'h0, convStart}, 32'h0);

    // R2 register field vectors
    for (int i = 0; i < NVEC; i++) begin
      busWr(REG_VEC[i][71:64], REG_VEC[i][63:32]);
      busRd(REG_VEC[i][71:64], rd);
      check("R2 readback", rd, REG_VEC[i][31:0]);
    end

    // R4 start while powered off
    busWr(8'h08, 32'h4000_0000);
    check("R4 off start", {31'h0, convStart}, 32'h0);
    busRd(8'h00, rd); check("R4 off started flag", rd, 32'h0);

    busWr(8'h34, 32'h0000_0005);
    busWr(8'h04, 32'h0000_0020);

    // R4 stabilization boundary
    busWr(8'h08, 32'h0000_0001);
    repeat (STAB - 1) @(negedge clk);
    busWr(8'h08, 32'h4000_0001);
    check("R4 start in window", {31'h0, convStart}, 32'h0);
    busWr(8'h08, 32'h4000_0001);
    check("R5 start pulse", {31'h0, convStart}, 32'h1);
    check("R5 channel", {27'h0, convChan}, 32'h5);
    busRd(8'h00, rd); check("R5 started flag", rd, 32'h10);
    check("R5 pulse ends", {31'h0, convStart}, 32'h0);
    busRd(8'h08, rd); check("R5 go bit self-clears", rd, 32'h1);

    // R9 start while busy
    busWr(8'h08, 32'h4000_0001);
    check("R9 busy start", {31'h0, convStart}, 32'h0);
    @(negedge clk);
    check("R9 busy start later", {31'h0, convStart}, 32'h0);

    // R6 / R7 capture and interrupt
    convRespond(12'hABC);
    check("R7 irq set", {31'h0, irq}, 32'h1);
    busRd(8'h00, rd); check("R6 done flag", rd, 32'h12);
    busRd(8'h4C, rd); check("R6 result", rd, 32'h0000_0ABC);
    busRd(8'h00, rd); check("R8 read clears done", rd, 32'h10);
    check("R7 irq clear", {31'h0, irq}, 32'h0);

    // R8 write-zero clears, write-one keeps
    busWr(8'h00, 32'h0);
    busRd(8'h00, rd); check("R8 write zero", rd, 32'h0);
    busWr(8'h08, 32'h4000_0001);
    check("R5 second start", {31'h0, convStart}, 32'h1);
    @(negedge clk);
    convRespond(12'h123);
    busWr(8'h00, 32'h12);
    busRd(8'h00, rd); check("R8 write one keeps", rd, 32'h12);
    busWr(8'h00, 32'h10);
    busRd(8'h00, rd); check("R8 clear done only", rd, 32'h10);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);

    // R7 interrupt disabled
    busWr(8'h04, 32'h0);
    busWr(8'h08, 32'h4000_0001);
    @(negedge clk);
    convRespond(12'h456);
    check("R7 irq disabled", {31'h0, irq}, 32'h0);
    busRd(8'h00, rd); check("R6 flag without irq", rd, 32'h12);
    busRd(8'h4C, rd); check("R6 result 2", rd, 32'h0000_0456);

    // R10 stray done while idle
    busWr(8'h00, 32'h0);
    convRespond(12'hFFF);
    busRd(8'h4C, rd); check("R10 result kept", rd, 32'h0000_0456);
    busRd(8'h00, rd); check("R10 flags kept", rd, 32'h0);

    // R3 nonzero trigger selection
    busWr(8'h08, 32'h5000_0001);
    check("R3 trig start", {31'h0, convStart}, 32'h0);
    busRd(8'h00, rd); check("R3 started flag", rd, 32'h0);
    busWr(8'h08, 32'h6000_0001);
    check("R3 trig start 2", {31'h0, convStart}, 32'h0);

    // R4 power cycle restarts window
    busWr(8'h08, 32'h0);
    busWr(8'h08, 32'h0000_0001);
    busWr(8'h08, 32'h4000_0001);
    check("R4 restart window", {31'h0, convStart}, 32'h0);
    busRd(8'h00, rd); check("R4 restart started flag", rd, 32'h0);

    finish();
  end

endmodule